// File: doc/BRIEF.md
# Activity Monitor Counter Bank

This block holds five 64-bit activity counters for a processor core. Each counter adds one in every clock cycle in which its own event input is high. A counter built as a cycle counter stops counting while the core sits in a wait-for-interrupt or wait-for-event low-power state. Which counters are cycle counters is fixed per counter by a parameter mask.

Software reaches the counters through two paths. The system-register path carries an access encoding, a privilege level (0 to 3), a security state and three enable bits. One cycle after a request it answers with exactly one of three outcomes: a completed access with read data, a trap naming the exception level that must handle it, or an undefined-access flag. A debugger or monitor on the chip bus can also read the counters over a memory-mapped path. That path shows each counter as two read-only 32-bit words.

Top module: `actmon_bank`

## Requirements
- R1: After reset every counter reads zero on both paths, and the register-path response outputs are all low.
- R2: A counter whose event input is high at a clock edge grows by exactly one at that edge, and it wraps from all-ones to zero. A counter whose event input is low keeps its value.
- R3: A counter whose bit in CYCLE_MASK is set (default mask 5'b00011, so counters 0 and 1) holds its value at any edge where core_wfi_i or core_wfe_i is high. Counters whose bit is clear keep counting in that state.
- R4: The memory-mapped read is combinational. On mm_word_i, word 2n returns bits [31:0] of counter n and word 2n+1 returns bits [63:32]. These are byte offsets 0x000+8n and 0x004+8n. Words for n greater than 4 return zero.
- R5: A register-path request addresses counter op2 only when op0=3, op1=3, CRn=15, CRm=9 and op2 is 0 to 4. Any other encoding raises sr_undef_o and changes no counter.
- R6: Three conditions cause a trap. Level 0 with ctl_user_en_i low traps to 1. Level 0 or 1, non-secure, with ctl_el2_en_i low traps to 2. Levels 0 to 2 with ctl_el3_en_i low trap to 3. When several apply, the lowest target wins. sr_trap_el_o holds the target (1, 2 or 3) and is 0 with no trap. A trapped access changes no counter.
- R7: A read that is neither trapped nor undefined completes at any level. sr_ack_o rises and sr_rdata_o carries the counter value from just before the request edge.
- R8: A level-3 write that is neither trapped nor undefined loads sr_wdata_i into the counter at the request edge, overriding any event increment in that cycle, and raises sr_ack_o.
- R9: A write at level 0, 1 or 2 that is not trapped is ignored and raises sr_undef_o.
- R10: Responses appear in the cycle after a request with sr_valid_i high. At most one of sr_ack_o, sr_trap_o and sr_undef_o is high. All three are low after a cycle with no request. sr_rdata_o is zero unless the response is a completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 5 | Per-counter event pulses |
| core_wfi_i | input | 1 | Core is in wait-for-interrupt |
| core_wfe_i | input | 1 | Core is in wait-for-event |
| sr_valid_i | input | 1 | Register-path request strobe |
| sr_write_i | input | 1 | Request is a write |
| sr_el_i | input | 2 | Privilege level of the requester |
| sr_nonsecure_i | input | 1 | Requester is non-secure |
| sr_op0_i | input | 2 | Encoding field op0 |
| sr_op1_i | input | 3 | Encoding field op1 |
| sr_crn_i | input | 4 | Encoding field CRn |
| sr_crm_i | input | 4 | Encoding field CRm |
| sr_op2_i | input | 3 | Encoding field op2, counter index |
| sr_wdata_i | input | 64 | Write data |
| ctl_user_en_i | input | 1 | Level-0 access enable |
| ctl_el2_en_i | input | 1 | Level-2 enable for non-secure levels 0 and 1 |
| ctl_el3_en_i | input | 1 | Level-3 enable for levels 0 to 2 |
| sr_ack_o | output | 1 | Access completed |
| sr_trap_o | output | 1 | Access trapped |
| sr_trap_el_o | output | 2 | Trap target level |
| sr_undef_o | output | 1 | Undefined access |
| sr_rdata_o | output | 64 | Read data |
| mm_word_i | input | 4 | Memory-mapped 32-bit word index |
| mm_rdata_o | output | 32 | Memory-mapped read data |

## Verification
An event increment and a register-path write to the same counter can fall in the same cycle. So can an event increment and a register-path read. The bench provokes both by raising event inputs at random while register requests arrive, and adds directed cases: an all-ones write alongside an event, then an event that wraps the counter. A reference model in the bench applies the write before the increment and returns read data from before the edge. It compares the response one cycle later and the memory-mapped word just after the edge.

// File: rtl/actmon_pkg.sv
package actmon_pkg;

  localparam logic [1:0] ENC_OP0 = 2'd3;
  localparam logic [2:0] ENC_OP1 = 3'd3;
  localparam logic [3:0] ENC_CRN = 4'd15;
  localparam logic [3:0] ENC_CRM = 4'd9;

  localparam logic [1:0] LVL_TOP = 2'd3;
  localparam logic [1:0] TRAP_NONE = 2'd0;

  // Encoding match for the counter register group
  function automatic logic enc_hit(logic [1:0] op0, logic [2:0] op1,
                                   logic [3:0] crn, logic [3:0] crm,
                                   logic [2:0] op2, int num);
    return (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN) &&
           (crm == ENC_CRM) && (int'(op2) < num);
  endfunction

  // Lowest trap target wins; TRAP_NONE when access may proceed
  function automatic logic [1:0] trap_target(logic [1:0] lvl, logic ns,
                                             logic user_en, logic el2_en,
                                             logic el3_en);
    if (lvl == 2'd0 && !user_en) return 2'd1;
    if (lvl <= 2'd1 && ns && !el2_en) return 2'd2;
    if (lvl != LVL_TOP && !el3_en) return 2'd3;
    return TRAP_NONE;
  endfunction

endpackage

// File: rtl/actmon_counter.sv
module actmon_counter #(
  parameter int W        = 64,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  logic         wait_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_o
);

  function automatic logic [W-1:0] bump(logic [W-1:0] cur);
    return cur + {{(W-1){1'b0}}, 1'b1};
  endfunction

  logic step_en;
  assign step_en = evt_i && !(IS_CYCLE && wait_i);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_o <= '0;
    else if (wr_en_i)  cnt_o <= wr_data_i;
    else if (step_en)  cnt_o <= bump(cnt_o);
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));

  assert_no_evt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !evt_i) |=> cnt_o == $past(cnt_o));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> cnt_o == $past(wr_data_i));

  generate
    if (IS_CYCLE) begin : g_cyc
      assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_i && !wr_en_i) |=> cnt_o == $past(cnt_o));
    end
  endgenerate

endmodule

// File: rtl/actmon_access.sv
module actmon_access
  import actmon_pkg::*;
#(
  parameter int NUM_CTR = 5,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [1:0]       req_lvl_i,
  input  logic             req_ns_i,
  input  logic [1:0]       op0_i,
  input  logic [2:0]       op1_i,
  input  logic [3:0]       crn_i,
  input  logic [3:0]       crm_i,
  input  logic [IDX_W-1:0] op2_i,
  input  logic             user_en_i,
  input  logic             el2_en_i,
  input  logic             el3_en_i,
  output logic             wr_go_o,
  output logic             rd_go_o,
  output logic             rsp_ack_o,
  output logic             rsp_trap_o,
  output logic [1:0]       rsp_trap_lvl_o,
  output logic             rsp_undef_o
);

  logic       hit;
  logic [1:0] tgt;
  logic       trapped;
  logic       low_write;
  logic       undef_c;

  assign hit       = enc_hit(op0_i, op1_i, crn_i, crm_i, op2_i, NUM_CTR);
  assign tgt       = trap_target(req_lvl_i, req_ns_i, user_en_i, el2_en_i, el3_en_i);
  assign trapped   = req_valid_i && hit && (tgt != TRAP_NONE);
  assign low_write = req_write_i && (req_lvl_i != LVL_TOP);
  assign undef_c   = req_valid_i && (!hit || (!trapped && low_write));
  assign wr_go_o   = req_valid_i && hit && !trapped && req_write_i && !low_write;
  assign rd_go_o   = req_valid_i && hit && !trapped && !req_write_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_ack_o      <= 1'b0;
      rsp_trap_o     <= 1'b0;
      rsp_trap_lvl_o <= TRAP_NONE;
      rsp_undef_o    <= 1'b0;
    end else begin
      rsp_ack_o      <= wr_go_o || rd_go_o;
      rsp_trap_o     <= trapped;
      rsp_trap_lvl_o <= trapped ? tgt : TRAP_NONE;
      rsp_undef_o    <= undef_c;
    end
  end

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_ack_o, rsp_trap_o, rsp_undef_o}));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !(rsp_ack_o || rsp_trap_o || rsp_undef_o));

  assert_trap_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap_o |-> (rsp_trap_lvl_o > $past(req_lvl_i)));

  assert_top_never_traps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_lvl_i == LVL_TOP) |=> !rsp_trap_o);

  assert_low_write_undef_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && req_lvl_i != LVL_TOP) |=> !rsp_ack_o);

  assert_single_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go_o && rd_go_o));

endmodule

// File: rtl/actmon_mmio.sv
module actmon_mmio #(
  parameter int NUM_CTR = 5,
  parameter int CTR_W   = 64,
  parameter int WA      = 4
) (
  input  logic [NUM_CTR-1:0][CTR_W-1:0] ctr_i,
  input  logic [WA-1:0]                 word_i,
  output logic [CTR_W/2-1:0]            rdata_o
);

  localparam int HALF_W = CTR_W / 2;
  localparam int SEL_W  = WA - 1;

  logic [SEL_W-1:0] sel;
  logic             upper;

  assign sel   = word_i[WA-1:1];
  assign upper = word_i[0];

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (sel == SEL_W'(i))
        rdata_o = upper ? ctr_i[i][HALF_W +: HALF_W] : ctr_i[i][0 +: HALF_W];
    end
  end

endmodule

// File: rtl/actmon_bank.sv
module actmon_bank #(
  parameter int                 NUM_CTR    = 5,
  parameter int                 CTR_W      = 64,
  parameter logic [NUM_CTR-1:0] CYCLE_MASK = 5'b00011,
  parameter int                 MM_WA      = $clog2(NUM_CTR) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] evt_i,
  input  logic               core_wfi_i,
  input  logic               core_wfe_i,
  input  logic               sr_valid_i,
  input  logic               sr_write_i,
  input  logic [1:0]         sr_el_i,
  input  logic               sr_nonsecure_i,
  input  logic [1:0]         sr_op0_i,
  input  logic [2:0]         sr_op1_i,
  input  logic [3:0]         sr_crn_i,
  input  logic [3:0]         sr_crm_i,
  input  logic [2:0]         sr_op2_i,
  input  logic [CTR_W-1:0]   sr_wdata_i,
  input  logic               ctl_user_en_i,
  input  logic               ctl_el2_en_i,
  input  logic               ctl_el3_en_i,
  output logic               sr_ack_o,
  output logic               sr_trap_o,
  output logic [1:0]         sr_trap_el_o,
  output logic               sr_undef_o,
  output logic [CTR_W-1:0]   sr_rdata_o,
  input  logic [MM_WA-1:0]   mm_word_i,
  output logic [CTR_W/2-1:0] mm_rdata_o
);

  localparam int IDX_W = 3;

  logic                            core_wait;
  logic                            wr_go;
  logic                            rd_go;
  logic [NUM_CTR-1:0]              ctr_wr;
  logic [NUM_CTR-1:0][CTR_W-1:0]   ctr_val;
  logic [CTR_W-1:0]                rd_sel;

  assign core_wait = core_wfi_i || core_wfe_i;

  actmon_access #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W)) u_access (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (sr_valid_i),
    .req_write_i    (sr_write_i),
    .req_lvl_i      (sr_el_i),
    .req_ns_i       (sr_nonsecure_i),
    .op0_i          (sr_op0_i),
    .op1_i          (sr_op1_i),
    .crn_i          (sr_crn_i),
    .crm_i          (sr_crm_i),
    .op2_i          (sr_op2_i),
    .user_en_i      (ctl_user_en_i),
    .el2_en_i       (ctl_el2_en_i),
    .el3_en_i       (ctl_el3_en_i),
    .wr_go_o        (wr_go),
    .rd_go_o        (rd_go),
    .rsp_ack_o      (sr_ack_o),
    .rsp_trap_o     (sr_trap_o),
    .rsp_trap_lvl_o (sr_trap_el_o),
    .rsp_undef_o    (sr_undef_o)
  );

  generate
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
      assign ctr_wr[g] = wr_go && (sr_op2_i == IDX_W'(g));
      actmon_counter #(.W(CTR_W), .IS_CYCLE(CYCLE_MASK[g])) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i[g]),
        .wait_i    (core_wait),
        .wr_en_i   (ctr_wr[g]),
        .wr_data_i (sr_wdata_i),
        .cnt_o     (ctr_val[g])
      );
    end
  endgenerate

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_CTR; i++)
      if (sr_op2_i == IDX_W'(i)) rd_sel = ctr_val[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sr_rdata_o <= '0;
    else if (rd_go) sr_rdata_o <= rd_sel;
    else            sr_rdata_o <= '0;
  end

  actmon_mmio #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .WA(MM_WA)) u_mmio (
    .ctr_i   (ctr_val),
    .word_i  (mm_word_i),
    .rdata_o (mm_rdata_o)
  );

  assert_write_needs_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_wr != '0) |-> (sr_el_i == 2'd3 && sr_write_i && sr_valid_i));

  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctr_wr));

  assert_rdata_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_ack_o |-> sr_rdata_o == '0);

endmodule

// File: tb/tb_actmon_bank.sv
module tb_actmon_bank;

  localparam int N = 5;
  localparam logic [N-1:0] CYC = 5'b00011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic        wfi = 1'b0, wfe = 1'b0;
  logic        valid = 1'b0, write = 1'b0, ns = 1'b0;
  logic [1:0]  el = 2'd0, op0 = 2'd3;
  logic [2:0]  op1 = 3'd3, op2 = 3'd0;
  logic [3:0]  crn = 4'd15, crm = 4'd9;
  logic [63:0] wdata = '0;
  logic        uen = 1'b1, e2en = 1'b1, e3en = 1'b1;
  logic [3:0]  mmw = 4'd0;
  logic        ack, trap, undef;
  logic [1:0]  trap_el;
  logic [63:0] rdata;
  logic [31:0] mmr;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [63:0] m [N];

  always #2 clk = ~clk;

  actmon_bank dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .core_wfi_i(wfi), .core_wfe_i(wfe),
    .sr_valid_i(valid), .sr_write_i(write), .sr_el_i(el), .sr_nonsecure_i(ns),
    .sr_op0_i(op0), .sr_op1_i(op1), .sr_crn_i(crn), .sr_crm_i(crm), .sr_op2_i(op2),
    .sr_wdata_i(wdata), .ctl_user_en_i(uen), .ctl_el2_en_i(e2en), .ctl_el3_en_i(e3en),
    .sr_ack_o(ack), .sr_trap_o(trap), .sr_trap_el_o(trap_el), .sr_undef_o(undef),
    .sr_rdata_o(rdata), .mm_word_i(mmw), .mm_rdata_o(mmr)
  );

  function automatic logic [1:0] ref_trap(logic [1:0] l, logic s, logic u, logic a, logic b);
    logic [1:0] t;
    t = 2'd0;
    if (!b && l < 2'd3) t = 2'd3;
    if (!a && s && l < 2'd2) t = 2'd2;
    if (!u && l == 2'd0) t = 2'd1;
    return t;
  endfunction

  function automatic logic [31:0] ref_mm(logic [3:0] w);
    int n;
    n = int'(w) / 2;
    if (n >= N) return 32'd0;
    return w[0] ? m[n][63:32] : m[n][31:0];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Inputs are already set while clk is low; model the edge, then compare.
  task automatic step(string tag);
    logic hit, e_ack, e_trap, e_undef;
    logic [1:0] e_tel, tt;
    logic [63:0] e_rd;
    hit = op0 == 2'd3 && op1 == 3'd3 && crn == 4'd15 && crm == 4'd9 && op2 < 3'd5;
    tt  = ref_trap(el, ns, uen, e2en, e3en);
    e_ack = 0; e_trap = 0; e_undef = 0; e_tel = 0; e_rd = 0;
    if (valid) begin
      if (!hit) e_undef = 1;
      else if (tt != 0) begin e_trap = 1; e_tel = tt; end
      else if (write && el != 2'd3) e_undef = 1;
      else begin e_ack = 1; if (!write) e_rd = m[op2]; end
    end
    for (int i = 0; i < N; i++) begin
      if (e_ack && write && int'(op2) == i) m[i] = wdata;
      else if (evt[i] && !(CYC[i] && (wfi || wfe))) m[i] = m[i] + 64'd1;
    end
    @(posedge clk); #1;
    check({tag, " ack R10"}, {63'd0, ack}, {63'd0, e_ack});
    check({tag, " trap R6"}, {63'd0, trap}, {63'd0, e_trap});
    check({tag, " trap_el R6"}, {62'd0, trap_el}, {62'd0, e_tel});
    check({tag, " undef R5/R9"}, {63'd0, undef}, {63'd0, e_undef});
    check({tag, " rdata R7"}, rdata, e_rd);
    check({tag, " mm R4"}, {32'd0, mmr}, {32'd0, ref_mm(mmw)});
    @(negedge clk);
  endtask

  task automatic req(logic v, logic w, logic [1:0] l, logic s, logic [2:0] idx, logic [63:0] d);
    valid = v; write = w; el = l; ns = s; op2 = idx; wdata = d;
    op0 = 2'd3; op1 = 3'd3; crn = 4'd15; crm = 4'd9;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'd4242);
    for (int i = 0; i < N; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state on both paths
    for (int w = 0; w < 2 * N; w++) begin
      mmw = 4'(w); #1;
      check("R1 reset mm", {32'd0, mmr}, 64'd0);
    end
    check("R1 reset resp", {61'd0, ack, trap, undef}, 64'd0);
    @(negedge clk);
    req(1, 0, 2'd0, 0, 3'd4, 0); mmw = 4'd9; step("R1 read after reset");
    req(0, 0, 0, 0, 0, 0);

    // R2 wrap, R8 write beats same-cycle event
    evt = 5'b00010; req(1, 1, 2'd3, 0, 3'd1, '1); mmw = 4'd3; step("R8 write vs event");
    req(0, 0, 0, 0, 0, 0); mmw = 4'd2; step("R2 wrap to zero");
    evt = 5'b00100; req(1, 1, 2'd3, 1, 3'd2, 64'h0000_0000_FFFF_FFFF); mmw = 4'd5; step("R8 load");
    req(0, 0, 0, 0, 0, 0); mmw = 4'd5; step("R2 carry into high half");
    req(1, 0, 2'd1, 1, 3'd2, 0); step("R7 read during event");

    // R3 cycle counters hold in wait states
    evt = 5'b11111; wfi = 1; mmw = 4'd0; step("R3 wfi hold c0");
    wfi = 0; wfe = 1; mmw = 4'd2; step("R3 wfe hold c1");
    mmw = 4'd8; step("R3 non-cycle counts");
    wfe = 0; mmw = 4'd0; step("R3 resume c0");
    evt = '0;

    // R6 trap priority
    uen = 0; e2en = 0; e3en = 0;
    req(1, 0, 2'd0, 1, 3'd0, 0); step("R6 all clear el0");
    req(1, 0, 2'd1, 1, 3'd0, 0); step("R6 el1 ns");
    req(1, 0, 2'd1, 0, 3'd0, 0); step("R6 el1 secure");
    req(1, 1, 2'd2, 0, 3'd0, 64'd5); mmw = 4'd0; step("R6 el2 trapped write");
    req(1, 1, 2'd3, 0, 3'd0, 64'd77); step("R8 el3 ignores enables");
    uen = 1; e2en = 1; e3en = 1;

    // R9 low write ignored; R5 bad encoding
    req(1, 1, 2'd2, 0, 3'd0, 64'd9); mmw = 4'd0; step("R9 el2 write");
    req(1, 1, 2'd3, 0, 3'd5, 64'd9); step("R5 op2 out of range");
    req(1, 1, 2'd3, 0, 3'd0, 64'd9); crm = 4'd8; step("R5 bad crm");
    req(0, 0, 0, 0, 0, 0); step("R10 idle");

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      evt  = N'($urandom);
      wfi  = ($urandom % 6) == 0;
      wfe  = ($urandom % 8) == 0;
      uen  = ($urandom % 4) != 0;
      e2en = ($urandom % 4) != 0;
      e3en = ($urandom % 4) != 0;
      req(($urandom % 3) != 0, ($urandom % 2) == 0, 2'($urandom), 1'($urandom),
          3'($urandom % 6), {$urandom, $urandom});
      if (($urandom % 16) == 0) op1 = 3'($urandom);
      mmw = 4'($urandom);
      step("R2/R7 random");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule